// File: doc/BRIEF.md
# Predicate Shadow Resolution Unit

This unit settles the fate of predicated vector-element operations in a multi-issue out-of-order core after they have already been issued. Issue hands it an allocation naming the predicate source register (by tag) and the set of element function units that took one element each. From the following cycle it holds a commit shadow over every allocated element. Those element units may compute, but they may not write the register file.

While the predicate register is still being produced, the unit waits on its tag as a write hazard, as any other blocked function unit would. When the matching result is broadcast, the unit captures the value and walks the elements in ascending order, one per clock. A one bit drops that element's shadow so it can write back. A zero bit drops the shadow and pulses that element's kill line, which cancels the element.

If the predicate is already available at allocation, the walk starts on the next cycle. A flush abandons everything and issues no releases and no kills.

Top module: `pred_shadow_unit`

## Requirements
- R1: While rst_ni is low, shadow_o, kill_o, done_o and busy_o are all zero.
- R2: An allocation accepted with alloc_ready_i low makes shadow_o equal alloc_mask_i from the next cycle. busy_o is high, and both hold unchanged while the unit waits.
- R3: While waiting, a result broadcast whose wb_tag_i differs from the allocated tag has no effect on shadow_o, kill_o, done_o or busy_o.
- R4: A matching broadcast captured at clock edge E starts the walk. Element k (bit k of the predicate, bit k of each mask and output vector) is resolved at edge E+1+k, for k from 0 up to the highest allocated index.
- R5: An allocated element whose predicate bit is 1 has its shadow bit dropped at its resolve edge, and its kill bit stays 0.
- R6: An allocated element whose predicate bit is 0 has its shadow bit dropped at its resolve edge, and its kill bit is high for exactly that one cycle. Shadow and kill are never both high for one element.
- R7: An element whose alloc_mask_i bit was 0 never sees shadow or kill.
- R8: done_o is high for exactly one cycle, set at the resolve edge of the highest allocated element (edge E+1 if the mask is empty). In that cycle busy_o is low and all shadows are clear, and a new allocation is accepted from that cycle on.
- R9: An allocation captured at edge A with alloc_ready_i high uses alloc_pred_i as the predicate. Element k resolves at edge A+1+k, with no wait.
- R10: flush_i captured at an edge clears shadow_o, kill_o, done_o and busy_o from that edge, with no kill issued. A later broadcast of the old tag has no effect.
- R11: An allocation presented while busy_o is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| flush_i | input | 1 | Abandon the current operation |
| alloc_valid_i | input | 1 | Allocation from issue |
| alloc_tag_i | input | TAG_W | Tag of the predicate source register |
| alloc_mask_i | input | NELEM | Element units allocated to this operation |
| alloc_ready_i | input | 1 | Predicate already available at allocation |
| alloc_pred_i | input | NELEM | Predicate value when alloc_ready_i is high |
| wb_valid_i | input | 1 | Register result broadcast |
| wb_tag_i | input | TAG_W | Tag of the broadcast result |
| wb_pred_i | input | NELEM | Broadcast value |
| shadow_o | output | NELEM | Per-element commit shadow |
| kill_o | output | NELEM | Per-element cancel pulse |
| done_o | output | 1 | Last allocated element resolved |
| busy_o | output | 1 | Operation in progress |

## Verification
Every output is registered. For an allocation captured at edge A, the shadows appear after A. For a walk that starts at edge E (the matching broadcast edge, or A itself when the predicate was ready), element k's shadow drop or kill pulse appears after edge E+1+k. done_o appears together with the last allocated element's resolution, and all outputs are idle one edge later. The driver computes these edge numbers from the requirements and queues one expected output snapshot per cycle. The monitor compares each snapshot at the falling edge of exactly that cycle, and it counts any snapshot left behind as a failure.

// File: rtl/psu_pkg.sv
package psu_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_RES  = 2'd2
  } psu_state_e;
endpackage

// File: rtl/psu_ctrl.sv
module psu_ctrl
  import psu_pkg::*;
#(
  parameter int NELEM = 8,
  parameter int TAG_W = 5,
  localparam int IDX_W = (NELEM > 1) ? $clog2(NELEM) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic             alloc_valid_i,
  input  logic [TAG_W-1:0] alloc_tag_i,
  input  logic [NELEM-1:0] alloc_mask_i,
  input  logic             alloc_ready_i,
  input  logic [NELEM-1:0] alloc_pred_i,
  input  logic             wb_valid_i,
  input  logic [TAG_W-1:0] wb_tag_i,
  input  logic [NELEM-1:0] wb_pred_i,
  output logic             accept_o,
  output logic             step_valid_o,
  output logic [IDX_W-1:0] step_idx_o,
  output logic             step_bit_o,
  output logic             done_o,
  output logic             busy_o
);
  psu_state_e       state_q;
  logic [TAG_W-1:0] tag_q;
  logic [NELEM-1:0] pred_q;
  logic [IDX_W-1:0] idx_q, last_q;
  logic             done_q;
  logic             wb_hit;

  function automatic logic [IDX_W-1:0] top_set(input logic [NELEM-1:0] m);
    logic [IDX_W-1:0] r;
    r = '0;
    for (int i = 0; i < NELEM; i++) if (m[i]) r = IDX_W'(i);
    return r;
  endfunction

  assign accept_o     = alloc_valid_i && (state_q == ST_IDLE) && !flush_i;
  assign wb_hit       = wb_valid_i && (wb_tag_i == tag_q);
  assign step_valid_o = (state_q == ST_RES) && !flush_i;
  assign step_idx_o   = idx_q;
  assign step_bit_o   = pred_q[idx_q];
  assign done_o       = done_q;
  assign busy_o       = (state_q != ST_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      tag_q   <= '0;
      pred_q  <= '0;
      idx_q   <= '0;
      last_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (flush_i) begin
        state_q <= ST_IDLE;
      end else begin
        unique case (state_q)
          ST_IDLE: if (accept_o) begin
            tag_q  <= alloc_tag_i;
            idx_q  <= '0;
            last_q <= top_set(alloc_mask_i);
            if (alloc_ready_i) begin
              pred_q  <= alloc_pred_i;
              state_q <= ST_RES;
            end else begin
              state_q <= ST_WAIT;
            end
          end
          ST_WAIT: if (wb_hit) begin
            pred_q  <= wb_pred_i;
            state_q <= ST_RES;
          end
          ST_RES: begin
            if (idx_q == last_q) begin
              done_q  <= 1'b1;
              state_q <= ST_IDLE;
            end else begin
              idx_q <= idx_q + 1'b1;
            end
          end
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end

  // R3: foreign tags do not end the wait
  assert_foreign_tag_held_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WAIT && !flush_i && !(wb_valid_i && wb_tag_i == tag_q)) |=> (state_q == ST_WAIT));

  // R8: done is a single-cycle pulse
  assert_done_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);

  // R11: no allocation taken while busy
  assert_busy_ignores_alloc_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WAIT && alloc_valid_i && !wb_hit) |=> $stable(tag_q));

  // R4: walk index moves up by one per cycle
  assert_walk_ascends_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RES && !flush_i && idx_q != last_q) |=> (idx_q == $past(idx_q) + 1'b1));
endmodule

// File: rtl/psu_lanes.sv
module psu_lanes #(
  parameter int NELEM = 8,
  localparam int IDX_W = (NELEM > 1) ? $clog2(NELEM) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic             load_i,
  input  logic [NELEM-1:0] load_mask_i,
  input  logic             step_valid_i,
  input  logic [IDX_W-1:0] step_idx_i,
  input  logic             step_bit_i,
  output logic [NELEM-1:0] shadow_o,
  output logic [NELEM-1:0] kill_o
);
  logic [NELEM-1:0] mask_o_q;

  for (genvar i = 0; i < NELEM; i++) begin : g_lane
    localparam logic [IDX_W-1:0] LANE = IDX_W'(i);
    logic m_q, sh_q, kl_q, hit;

    assign hit = step_valid_i && (step_idx_i == LANE) && m_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        m_q  <= 1'b0;
        sh_q <= 1'b0;
        kl_q <= 1'b0;
      end else begin
        kl_q <= 1'b0;
        if (flush_i) begin
          m_q  <= 1'b0;
          sh_q <= 1'b0;
        end else if (load_i) begin
          m_q  <= load_mask_i[i];
          sh_q <= load_mask_i[i];
        end else if (hit) begin
          sh_q <= 1'b0;
          kl_q <= !step_bit_i;
        end
      end
    end

    assign shadow_o[i] = sh_q;
    assign kill_o[i]   = kl_q;
    assign mask_o_q[i] = m_q;
  end

  // R6: shadow and kill exclusive per element
  assert_shadow_kill_excl_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (shadow_o & kill_o) == '0);

  // R7: unallocated lanes stay silent
  assert_unalloc_silent_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((shadow_o | kill_o) & ~mask_o_q) == '0);

  // R10: flush leaves nothing behind
  assert_flush_clears_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (shadow_o == '0 && kill_o == '0));

  // R2: a shadow only rises on an accepted allocation
  assert_shadow_rise_on_load_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((shadow_o & ~$past(shadow_o)) != '0) |-> $past(load_i));
endmodule

// File: rtl/pred_shadow_unit.sv
module pred_shadow_unit #(
  parameter int NELEM = 8,
  parameter int TAG_W = 5,
  localparam int IDX_W = (NELEM > 1) ? $clog2(NELEM) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic             alloc_valid_i,
  input  logic [TAG_W-1:0] alloc_tag_i,
  input  logic [NELEM-1:0] alloc_mask_i,
  input  logic             alloc_ready_i,
  input  logic [NELEM-1:0] alloc_pred_i,
  input  logic             wb_valid_i,
  input  logic [TAG_W-1:0] wb_tag_i,
  input  logic [NELEM-1:0] wb_pred_i,
  output logic [NELEM-1:0] shadow_o,
  output logic [NELEM-1:0] kill_o,
  output logic             done_o,
  output logic             busy_o
);
  logic             accept;
  logic             step_valid;
  logic [IDX_W-1:0] step_idx;
  logic             step_bit;

  psu_ctrl #(.NELEM(NELEM), .TAG_W(TAG_W)) i_ctrl (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .flush_i       (flush_i),
    .alloc_valid_i (alloc_valid_i),
    .alloc_tag_i   (alloc_tag_i),
    .alloc_mask_i  (alloc_mask_i),
    .alloc_ready_i (alloc_ready_i),
    .alloc_pred_i  (alloc_pred_i),
    .wb_valid_i    (wb_valid_i),
    .wb_tag_i      (wb_tag_i),
    .wb_pred_i     (wb_pred_i),
    .accept_o      (accept),
    .step_valid_o  (step_valid),
    .step_idx_o    (step_idx),
    .step_bit_o    (step_bit),
    .done_o        (done_o),
    .busy_o        (busy_o)
  );

  psu_lanes #(.NELEM(NELEM)) i_lanes (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .flush_i      (flush_i),
    .load_i       (accept),
    .load_mask_i  (alloc_mask_i),
    .step_valid_i (step_valid),
    .step_idx_i   (step_idx),
    .step_bit_i   (step_bit),
    .shadow_o     (shadow_o),
    .kill_o       (kill_o)
  );

  // R8: completion implies every shadow resolved
  assert_done_all_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (shadow_o == '0 && !busy_o));

  // R5: a shadow drop comes from a walk step, never spontaneously
  assert_drop_needs_step_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (($past(shadow_o) & ~shadow_o) != '0) |-> ($past(step_valid) || $past(flush_i)));
endmodule

// File: tb/test_pred_shadow_unit.sv
module test_pred_shadow_unit;
  localparam int N = 8;
  localparam int T = 5;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         flush_i = 1'b0;
  logic         alloc_valid_i = 1'b0;
  logic [T-1:0] alloc_tag_i = '0;
  logic [N-1:0] alloc_mask_i = '0;
  logic         alloc_ready_i = 1'b0;
  logic [N-1:0] alloc_pred_i = '0;
  logic         wb_valid_i = 1'b0;
  logic [T-1:0] wb_tag_i = '0;
  logic [N-1:0] wb_pred_i = '0;
  logic [N-1:0] shadow_o, kill_o;
  logic         done_o, busy_o;

  pred_shadow_unit #(.NELEM(N), .TAG_W(T)) i_pred_shadow_unit (
    .clk_i(clk_i), .rst_ni(rst_ni), .flush_i(flush_i),
    .alloc_valid_i(alloc_valid_i), .alloc_tag_i(alloc_tag_i),
    .alloc_mask_i(alloc_mask_i), .alloc_ready_i(alloc_ready_i),
    .alloc_pred_i(alloc_pred_i), .wb_valid_i(wb_valid_i),
    .wb_tag_i(wb_tag_i), .wb_pred_i(wb_pred_i),
    .shadow_o(shadow_o), .kill_o(kill_o), .done_o(done_o), .busy_o(busy_o)
  );

  always #10 clk_i = ~clk_i;

  typedef struct {
    int           n;
    logic [N-1:0] sh;
    logic [N-1:0] kl;
    logic         dn;
    logic         bz;
    string        lab;
  } exp_t;

  exp_t q[$];
  int   cyc = 0;
  int   checks = 0;
  int   fails = 0;

  always @(posedge clk_i) cyc = cyc + 1;

  task automatic expect_at(input int n, input logic [N-1:0] sh, input logic [N-1:0] kl,
                           input logic dn, input logic bz, input string lab);
    exp_t e;
    e.n = n; e.sh = sh; e.kl = kl; e.dn = dn; e.bz = bz; e.lab = lab;
    q.push_back(e);
  endtask

  // monitor: compare the snapshot due in this cycle
  always @(negedge clk_i) begin
    exp_t e;
    while (q.size() > 0 && q[0].n < cyc) begin
      e = q.pop_front();
      checks++; fails++;
      $display("FAIL %s: snapshot for cycle %0d missed (actual cycle %0d, expected %0d)",
               e.lab, e.n, cyc, e.n);
    end
    if (q.size() > 0 && q[0].n == cyc) begin
      e = q.pop_front();
      checks++;
      if (shadow_o !== e.sh || kill_o !== e.kl || done_o !== e.dn || busy_o !== e.bz) begin
        fails++;
        $display("FAIL %s @%0d: actual sh=%b kl=%b dn=%b bz=%b expected sh=%b kl=%b dn=%b bz=%b",
                 e.lab, cyc, shadow_o, kill_o, done_o, busy_o, e.sh, e.kl, e.dn, e.bz);
      end
    end
  end

  task automatic step();
    @(negedge clk_i);
    #1;
  endtask

  // one operation; expected snapshots follow R2, R4, R5, R6, R7, R8, R9
  task automatic op(input logic [N-1:0] mask, input logic rdy, input logic [N-1:0] val,
                    input logic [T-1:0] tag, input int waitc, input bit foreign);
    int t0, es, en, last, r;
    logic [N-1:0] sh, kl;
    string lab;
    last = 0;
    for (int i = 0; i < N; i++) if (mask[i]) last = i;
    t0 = cyc + 1;
    es = rdy ? t0 : t0 + waitc + 1;
    en = es + last + 1;
    for (int n = t0; n <= en + 1; n++) begin
      if (n < es) begin
        expect_at(n, mask, '0, 1'b0, 1'b1, "R2 R3 wait");
      end else if (n <= en) begin
        r  = n - es;
        sh = mask;
        kl = '0;
        for (int k = 0; k < r; k++) sh[k] = 1'b0;
        if (r >= 1 && mask[r-1] && !val[r-1]) kl[r-1] = 1'b1;
        lab = rdy ? "R9 R5 R6 R7 walk" : "R4 R5 R6 R7 walk";
        if (n == en) lab = "R8 done";
        expect_at(n, sh, kl, n == en, n < en, lab);
      end else begin
        expect_at(n, '0, '0, 1'b0, 1'b0, "R8 idle");
      end
    end
    alloc_valid_i = 1'b1; alloc_mask_i = mask; alloc_tag_i = tag;
    alloc_ready_i = rdy;  alloc_pred_i = rdy ? val : ~val;
    step();
    alloc_valid_i = 1'b0; alloc_pred_i = '0;
    if (!rdy) begin
      for (int i = 0; i < waitc; i++) begin
        wb_valid_i = foreign; wb_tag_i = tag ^ 5'd1; wb_pred_i = ~val;
        step();
      end
      wb_valid_i = 1'b1; wb_tag_i = tag; wb_pred_i = val;
      step();
      wb_valid_i = 1'b0;
    end
    while (cyc < en + 1) step();
  endtask

  initial begin
    #(200000 * 20);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int c;
    // R1: outputs idle during reset
    for (int n = 1; n <= 3; n++) expect_at(n, '0, '0, 1'b0, 1'b0, "R1 reset");
    while (cyc < 3) step();
    rst_ni = 1'b1;
    step();

    op(8'hFF, 1'b0, 8'hA5, 5'd3, 3, 1'b1);   // R2 R3 R4 mixed bits
    op(8'h56, 1'b1, 8'h0F, 5'd7, 0, 1'b0);   // R9 R7 sparse mask
    op(8'h00, 1'b1, 8'hFF, 5'd9, 0, 1'b0);   // R8 empty mask
    op(8'h80, 1'b0, 8'h00, 5'd12, 0, 1'b0);  // R4 R6 top lane killed
    op(8'h0B, 1'b0, 8'hFF, 5'd4, 2, 1'b0);   // R5 all released

    // R11 and R10: busy ignores alloc, flush abandons, stale tag ignored
    c = cyc;
    expect_at(c + 1, 8'h0F, '0, 1'b0, 1'b1, "R2 alloc");
    expect_at(c + 2, 8'h0F, '0, 1'b0, 1'b1, "R11 busy alloc");
    expect_at(c + 3, '0, '0, 1'b0, 1'b0, "R10 flush");
    expect_at(c + 4, '0, '0, 1'b0, 1'b0, "R10 stale tag");
    expect_at(c + 5, '0, '0, 1'b0, 1'b0, "R10 stale tag");
    alloc_valid_i = 1'b1; alloc_mask_i = 8'h0F; alloc_tag_i = 5'd2; alloc_ready_i = 1'b0;
    step();
    alloc_mask_i = 8'hF0; alloc_ready_i = 1'b1; alloc_pred_i = 8'h00;
    step();
    alloc_valid_i = 1'b0; flush_i = 1'b1;
    step();
    flush_i = 1'b0; wb_valid_i = 1'b1; wb_tag_i = 5'd2; wb_pred_i = 8'h00;
    step();
    wb_valid_i = 1'b0;
    step(); step();

    op(8'hC3, 1'b1, 8'h41, 5'd1, 0, 1'b0);   // R9 after flush

    step(); step();
    if (q.size() != 0) begin
      checks++; fails++;
      $display("FAIL queue: actual %0d left expected 0", q.size());
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule